// File: doc/BRIEF.md
# Transmit Holding Buffer with Sticky Status Flags

This block is the transmit-side buffer of a two-wire serial bus controller. Software writes a byte into a holding register. When the bus engine asks for the next byte and the holding register is full, the byte moves into the shift register that drives the wire.

Two sticky status flags tell software how far the transmission has got. The empty flag says the holding register can take a new byte. The end flag says a complete frame has gone out. Each flag is set by several bus events. A flag is cleared in one of two ways: software writes data into the holding register, or software writes 0 to the flag after it has read that flag as 1.

The end flag follows one set rule in two-wire bus format and a different rule in clocked synchronous format. The two flags are read and written through an 8-bit status register. The six lower bits of that register are status bits owned by other parts of the controller and are only passed through.

Top module: `txbuf_status`

## Requirements
- R1: After reset, status bits 7 and 6 read 0, `hold_full` is 0 and `shift_load` is 0.
- R2: `cpu_rdata` is {empty flag (bit 7), end flag (bit 6), `aux_flags` (bits 5:0)}. A status write has no effect on bits 5:0.
- R3: When `bus_load_req` is high and the holding register is full, `shift_load` pulses in that cycle. In the next cycle `shift_data` holds the byte, `hold_full` is 0 and the empty flag is 1. When the holding register is empty, a load request does nothing.
- R4: The empty flag is set in the cycle after any of these events: `bus_start`, `slv_rx2tx`, or a 0-to-1 change of `tx_mode`. A `tx_mode` that stays high does not set it again.
- R5: A write to `hold_wdata` (`hold_wr`) sets `hold_full`, clears both flags and replaces any byte still waiting in the holding register.
- R6: A status write with bit 7 (or bit 6) at 0 clears that flag only if a status read since the last status write returned that bit as 1. Every status write uses up that permission. Writing 1 has no effect.
- R7: With `fmt_sync`=0, the end flag is set on `bus_ninth_rise` only while the empty flag is 1. In this format `bus_last_bit` is ignored.
- R8: With `fmt_sync`=1, the end flag is set on `bus_last_bit`. In this format `bus_ninth_rise` is ignored.
- R9: When a hardware set event and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R10: When `hold_wr` and a load fall in the same cycle, the old byte goes to `shift_data`, the new byte stays held, `hold_full` stays 1 and the empty flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | Status register read strobe |
| cpu_wr | input | 1 | Status register write strobe |
| cpu_wdata | input | 8 | Status write data |
| cpu_rdata | output | 8 | Status register value |
| aux_flags | input | 6 | Other status bits, shown in bits 5:0 |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Byte to transmit |
| bus_start | input | 1 | Start or repeated start issued |
| bus_ninth_rise | input | 1 | Ninth clock rising edge (bus format) |
| bus_last_bit | input | 1 | Last frame bit sent (synchronous format) |
| bus_load_req | input | 1 | Shift register requests the next byte |
| tx_mode | input | 1 | Transmit mode select (level) |
| slv_rx2tx | input | 1 | Slave direction changed from receive to transmit |
| fmt_sync | input | 1 | 1 = clocked synchronous format |
| hold_full | output | 1 | Holding register holds a byte |
| shift_load | output | 1 | Holding-to-shift transfer this cycle |
| shift_data | output | DATA_W | Byte in the shift register |

## Verification
The hardest case to reach from the ports is a permitted software clear that lands in the same cycle as a set event. The flag must already be 1, software must have read it, and the write of 0 must then coincide with a set event. The stimulus reaches it in order: a start event sets the flag, a status read arms the clear, and the write of 0 is driven in the same cycle as a second start (or, for the end flag, a last-bit event). Other sequences check the handshake in the opposite direction: a write of 0 with no read before it, and a write of 0 after an earlier write has already used up the permission.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned EMPTY_POS = 7;
   localparam int unsigned END_POS   = 6;
   localparam int unsigned AUX_W     = STAT_W - 2;
endpackage

// File: rtl/txbuf_flag.sv
module txbuf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic data_clr,
   input  logic rd_strobe,
   input  logic wr_strobe,
   input  logic wr_bit,
   output logic q
);
   logic armed_q;
   logic sw_clr;

   assign sw_clr = wr_strobe & ~wr_bit & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         // a set event has priority over either kind of clear
         q <= hw_set | (q & ~(data_clr | sw_clr));
         if (!q)
            armed_q <= 1'b0;
         else if (rd_strobe)
            armed_q <= 1'b1;
         else if (wr_strobe)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/txbuf_hold.sv
module txbuf_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load_req,
   output logic              full,
   output logic              load_fire,
   output logic [DATA_W-1:0] shift_data
);
   logic [DATA_W-1:0] hold_q;

   assign load_fire = load_req & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         full       <= 1'b0;
         shift_data <= '0;
      end else begin
         if (load_fire)
            shift_data <= hold_q;
         if (wr) begin
            hold_q <= wdata;
            full   <= 1'b1;
         end else if (load_fire) begin
            full   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txbuf_end_src.sv
module txbuf_end_src #(
   parameter bit SYNC_FMT_EN = 1'b1
) (
   input  logic fmt_sync,
   input  logic ninth_rise,
   input  logic last_bit,
   input  logic empty,
   output logic set
);
   generate
      if (SYNC_FMT_EN) begin : g_dual
         assign set = fmt_sync ? last_bit : (ninth_rise & empty);
      end else begin : g_bus_only
         logic unused_sync;
         assign unused_sync = fmt_sync ^ last_bit;
         assign set = ninth_rise & empty;
      end
   endgenerate
endmodule

// File: rtl/txbuf_status.sv
module txbuf_status
   import txbuf_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          SYNC_FMT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   input  logic [5:0]        aux_flags,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_wdata,
   input  logic              bus_start,
   input  logic              bus_ninth_rise,
   input  logic              bus_last_bit,
   input  logic              bus_load_req,
   input  logic              tx_mode,
   input  logic              slv_rx2tx,
   input  logic              fmt_sync,
   output logic              hold_full,
   output logic              shift_load,
   output logic [DATA_W-1:0] shift_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("txbuf_status: DATA_W must be at least 1");
      end
      if (STAT_W != 8 || AUX_W != 6) begin : g_bad_stat
         $error("txbuf_status: status layout must be 8 bits with 6 aux bits");
      end
   endgenerate

   logic tx_mode_q;
   logic tx_rise;
   logic empty_q, end_q;
   logic empty_set, end_set;
   logic load_fire;
   logic unused_wbits;

   assign unused_wbits = ^cpu_wdata[AUX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_mode_q <= 1'b0;
      else        tx_mode_q <= tx_mode;
   end
   assign tx_rise = tx_mode & ~tx_mode_q;

   txbuf_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (hold_wr),
      .wdata      (hold_wdata),
      .load_req   (bus_load_req),
      .full       (hold_full),
      .load_fire  (load_fire),
      .shift_data (shift_data)
   );
   assign shift_load = load_fire;

   // a load that coincides with a new write leaves the buffer full
   assign empty_set = (load_fire & ~hold_wr) | bus_start | tx_rise | slv_rx2tx;

   txbuf_end_src #(.SYNC_FMT_EN(SYNC_FMT_EN)) u_end_src (
      .fmt_sync   (fmt_sync),
      .ninth_rise (bus_ninth_rise),
      .last_bit   (bus_last_bit),
      .empty      (empty_q),
      .set        (end_set)
   );

   txbuf_flag u_empty (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_set    (empty_set),
      .data_clr  (hold_wr),
      .rd_strobe (cpu_rd),
      .wr_strobe (cpu_wr),
      .wr_bit    (cpu_wdata[EMPTY_POS]),
      .q         (empty_q)
   );

   txbuf_flag u_end (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_set    (end_set),
      .data_clr  (hold_wr),
      .rd_strobe (cpu_rd),
      .wr_strobe (cpu_wr),
      .wr_bit    (cpu_wdata[END_POS]),
      .q         (end_q)
   );

   assign cpu_rdata = {empty_q, end_q, aux_flags};
endmodule

// File: rtl/txbuf_status_chk.sv
module txbuf_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_wr,
   input logic [7:0] cpu_wdata,
   input logic [7:0] cpu_rdata,
   input logic       hold_wr,
   input logic       hold_full,
   input logic       shift_load,
   input logic       bus_load_req,
   input logic       bus_start,
   input logic       bus_ninth_rise,
   input logic       bus_last_bit,
   input logic       fmt_sync
);
   assert_load_sets_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_load && !hold_wr) |=> cpu_rdata[7]);

   assert_load_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_load |-> (hold_full && bus_load_req));

   assert_start_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> cpu_rdata[7]);

   assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> hold_full);

   assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_wdata[7] && cpu_rdata[7] && !hold_wr) |=> cpu_rdata[7]);

   assert_ninth_sets_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_sync && bus_ninth_rise && cpu_rdata[7]) |=> cpu_rdata[6]);

   assert_last_bit_sets_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sync && bus_last_bit) |=> cpu_rdata[6]);

   assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && cpu_wr && !cpu_wdata[7]) |=> cpu_rdata[7]);
endmodule

bind txbuf_status txbuf_status_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_wr         (cpu_wr),
   .cpu_wdata      (cpu_wdata),
   .cpu_rdata      (cpu_rdata),
   .hold_wr        (hold_wr),
   .hold_full      (hold_full),
   .shift_load     (shift_load),
   .bus_load_req   (bus_load_req),
   .bus_start      (bus_start),
   .bus_ninth_rise (bus_ninth_rise),
   .bus_last_bit   (bus_last_bit),
   .fmt_sync       (fmt_sync)
);

// File: tb/txbuf_status_bench.sv
`timescale 1ns/1ps
module txbuf_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [5:0] aux_flags = '0;
   logic       hold_wr = 1'b0;
   logic [7:0] hold_wdata = '0;
   logic       bus_start = 1'b0, bus_ninth_rise = 1'b0, bus_last_bit = 1'b0;
   logic       bus_load_req = 1'b0, tx_mode = 1'b0, slv_rx2tx = 1'b0, fmt_sync = 1'b0;
   logic       hold_full, shift_load;
   logic [7:0] shift_data;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   txbuf_status u_txbuf_status (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .aux_flags(aux_flags),
      .hold_wr(hold_wr), .hold_wdata(hold_wdata), .bus_start(bus_start),
      .bus_ninth_rise(bus_ninth_rise), .bus_last_bit(bus_last_bit),
      .bus_load_req(bus_load_req), .tx_mode(tx_mode), .slv_rx2tx(slv_rx2tx),
      .fmt_sync(fmt_sync), .hold_full(hold_full), .shift_load(shift_load),
      .shift_data(shift_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic clear_pulses();
      cpu_rd = 0; cpu_wr = 0; hold_wr = 0; bus_start = 0; bus_ninth_rise = 0;
      bus_last_bit = 0; bus_load_req = 0; slv_rx2tx = 0;
   endtask

   task automatic put_byte(input logic [7:0] d);
      hold_wr = 1; hold_wdata = d; tick(); clear_pulses();
   endtask

   task automatic rd_stat(output logic [7:0] v);
      cpu_rd = 1; #1 v = cpu_rdata; tick(); clear_pulses();
   endtask

   task automatic wr_stat(input logic [7:0] d);
      cpu_wr = 1; cpu_wdata = d; tick(); clear_pulses();
   endtask

   task automatic t_reset();
      chk("R1 empty", cpu_rdata[7], 0);
      chk("R1 end", cpu_rdata[6], 0);
      chk("R1 hold_full", hold_full, 0);
      chk("R1 shift_load", shift_load, 0);
   endtask

   task automatic t_aux();
      aux_flags = 6'h2A; #1;
      chk("R2 aux pass", cpu_rdata[5:0], 6'h2A);
      wr_stat(8'h15);
      chk("R2 aux after write", cpu_rdata[5:0], 6'h2A);
   endtask

   task automatic t_load();
      put_byte(8'hA5);
      chk("R5 full", hold_full, 1);
      chk("R5 empty clr", cpu_rdata[7], 0);
      bus_load_req = 1; #1;
      chk("R3 load pulse", shift_load, 1);
      tick(); clear_pulses();
      chk("R3 shift data", shift_data, 8'hA5);
      chk("R3 not full", hold_full, 0);
      chk("R3 empty set", cpu_rdata[7], 1);
      bus_load_req = 1; #1;
      chk("R3 no load when empty", shift_load, 0);
      tick(); clear_pulses();
      chk("R3 data kept", shift_data, 8'hA5);
   endtask

   task automatic t_overwrite();
      put_byte(8'h11);
      put_byte(8'h22);
      bus_load_req = 1; tick(); clear_pulses();
      chk("R5 overwrite", shift_data, 8'h22);
   endtask

   task automatic t_set_events();
      put_byte(8'h01);
      bus_start = 1; tick(); clear_pulses();
      chk("R4 start", cpu_rdata[7], 1);
      put_byte(8'h02);
      tx_mode = 1; tick();
      chk("R4 tx rise", cpu_rdata[7], 1);
      put_byte(8'h03);
      chk("R4 tx level no retrigger", cpu_rdata[7], 0);
      slv_rx2tx = 1; tick(); clear_pulses();
      chk("R4 rx2tx", cpu_rdata[7], 1);
   endtask

   task automatic t_sw_clear();
      logic [7:0] v;
      wr_stat(8'h00);
      chk("R6 no read no clear", cpu_rdata[7], 1);
      rd_stat(v);
      chk("R6 read sees 1", v[7], 1);
      wr_stat(8'hFF);
      chk("R6 write one", cpu_rdata[7], 1);
      wr_stat(8'h00);
      chk("R6 arm used up", cpu_rdata[7], 1);
      rd_stat(v);
      wr_stat(8'h00);
      chk("R6 clear", cpu_rdata[7], 0);
   endtask

   task automatic t_end_bus();
      logic [7:0] v;
      fmt_sync = 0;
      bus_ninth_rise = 1; tick(); clear_pulses();
      chk("R7 ninth while not empty", cpu_rdata[6], 0);
      bus_start = 1; tick(); clear_pulses();
      bus_last_bit = 1; tick(); clear_pulses();
      chk("R7 last bit ignored", cpu_rdata[6], 0);
      bus_ninth_rise = 1; tick(); clear_pulses();
      chk("R7 ninth sets", cpu_rdata[6], 1);
      rd_stat(v);
      wr_stat(8'h80);
      chk("R6 end cleared", cpu_rdata[6], 0);
      chk("R6 empty kept", cpu_rdata[7], 1);
   endtask

   task automatic t_end_sync();
      fmt_sync = 1;
      bus_ninth_rise = 1; tick(); clear_pulses();
      chk("R8 ninth ignored", cpu_rdata[6], 0);
      bus_last_bit = 1; tick(); clear_pulses();
      chk("R8 last bit sets", cpu_rdata[6], 1);
      put_byte(8'h55);
      chk("R5 end clr by data", cpu_rdata[6], 0);
      chk("R5 empty clr by data", cpu_rdata[7], 0);
   endtask

   task automatic t_race();
      logic [7:0] v;
      bus_start = 1; bus_last_bit = 1; tick(); clear_pulses();
      rd_stat(v);
      chk("R9 both read 1", v[7:6], 2'b11);
      bus_start = 1; bus_last_bit = 1; cpu_wr = 1; cpu_wdata = 8'h00;
      tick(); clear_pulses();
      chk("R9 empty set wins", cpu_rdata[7], 1);
      chk("R9 end set wins", cpu_rdata[6], 1);
   endtask

   task automatic t_collide();
      put_byte(8'h33);
      hold_wr = 1; hold_wdata = 8'h44; bus_load_req = 1; tick(); clear_pulses();
      chk("R10 old byte shifted", shift_data, 8'h33);
      chk("R10 still full", hold_full, 1);
      chk("R10 empty low", cpu_rdata[7], 0);
      bus_load_req = 1; tick(); clear_pulses();
      chk("R10 new byte shifted", shift_data, 8'h44);
      chk("R3 empty after load", cpu_rdata[7], 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_aux();
      t_load();
      t_overwrite();
      t_set_events();
      t_sw_clear();
      t_end_bus();
      t_end_sync();
      t_race();
      t_collide();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule